// File: doc/BRIEF.md
# Inter-Processor and Interval-Timer Interrupt Controller

This block produces inter-processor interrupt lines and interval-timer interrupt lines for four processors. Its centre is one 64-bit control word in which each field obeys its own write rule. Some fields clear when a one is written to them. Some set when a one is written. One field sets only while it is still zero. One command bit wipes a whole byte. A request nibble raises the matching inter-processor bits. Each processor also has a 25-bit skip counter that counts down on every rising edge of a shared timer tick. Bit 24 of the counter latches once the count wraps below zero. From then on, every tick raises that processor's timer-interrupt bit in the control word.

Software reaches the block through one 64-bit read/write port. A 2-bit identifier of the requesting processor is folded into every read of the control word. Interrupt bits are cleared by writing ones to them. Timer-interrupt bits can only be set by the counters. A read of an offset that does not exist returns all ones and raises an error flag in the same cycle.

Top module: `ipi_timer_ctl`

## Requirements
- R1: After reset, the control word at offset 0x080 holds 0x0000_0008_0000_0000. All four skip counters read 0, and every interrupt output is low.
- R2: A read at offset 0x080 returns the stored control word with `cpu_id` ORed into bits [1:0]. Read data is combinational, valid in the same cycle as `rd_en`.
- R3: A control-word write clears every stored bit whose data bit is 1 under mask 0x1000_0FF0. That mask covers timer bits [7:4], inter-processor bits [11:8] and bit 28. The write takes effect at the next clock edge.
- R4: In a control-word write with data bit 20 set, stored bits [23:16] become zero. With data bit 20 clear, the ones in data bits [23:20] are ORed into stored bits [23:20].
- R5: When data bit 20 is clear, data bits [19:16] are ORed into stored bits [19:16], but only if stored bits [19:16] were all zero before the write. Otherwise the field is left unchanged.
- R6: Ones in data bits [15:12] set stored bits [11:8]. A set wins over a clear in the same write. `ipi_o[i]` follows stored bit 8+i.
- R7: Stored bits [43:40] take data bits [43:40] on every control-word write. No write changes any other stored bit. Bit 35 keeps its reset value, and bit 28 can only be cleared.
- R8: The skip counters for processors 0, 1, 2 and 3 sit at offsets 0x380, 0x3C0, 0x700 and 0x740. A counter write stores data bits [23:0] and clears bit 24. A counter read returns the 25-bit value zero-extended to 64 bits.
- R9: On each clock where `tick` is high and was low in the previous cycle, every counter becomes ((value-1) mod 2^25) with bit 24 held once set. A held-high or falling `tick` does nothing.
- R10: When a decremented counter has bit 24 set, timer bit 4+i is set in the same edge. `tmr_irq_o[i]` equals timer bit 4+i. It drops one cycle after a write clears that bit.
- R11: If a tick sets timer bit 4+i in the same cycle that a write clears it, the bit ends set. If a counter is written in the same cycle as a tick edge, the written value is stored, that counter does not decrement, and it raises no timer bit.
- R12: A write to any offset other than the five above changes nothing. A read of such an offset returns all ones with `rd_err` high in that cycle. `rd_err` is low on every mapped read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Register byte offset |
| wdata | input | 64 | Write data |
| cpu_id | input | 2 | Identifier of the requesting processor |
| tick | input | 1 | Interval timer level; its rising edges count |
| rdata | output | 64 | Read data, combinational |
| rd_err | output | 1 | Read of an unmapped offset |
| ipi_o | output | 4 | Inter-processor interrupt per processor |
| tmr_irq_o | output | 4 | Interval-timer interrupt per processor |

## Verification
Two functions can land on the same edge. A software write can clear a timer bit while a tick edge raises it, and a software write can load a counter while a tick edge decrements it. The bench provokes both by asserting `tick` in the very cycle of the write. It then judges the result against a behavioural model that applies the write before the tick: the timer bit ends set, and the loaded counter keeps its written value with no interrupt. Sticky overflow and the single count for a long tick pulse are checked by reading the counters back.

// File: rtl/itc_pkg.sv
package itc_pkg;
  localparam int NCPU     = 4;
  localparam int DW       = 64;
  localparam int AW       = 12;
  localparam int CNT_W    = 25;
  localparam int LOAD_W   = CNT_W - 1;
  localparam int IDW      = $clog2(NCPU);

  localparam logic [AW-1:0] OFF_CTRL = 12'h080;

  localparam logic [DW-1:0] CTRL_RST  = 64'h0000_0008_0000_0000;
  localparam logic [DW-1:0] CLR1_MASK = 64'h0000_0000_1000_0FF0;

  localparam int TMR_LO   = 4;
  localparam int IPI_LO   = 8;
  localparam int REQ_LO   = 12;
  localparam int ONCE_LO  = 16;
  localparam int SET_LO   = 20;
  localparam int WIPE_BIT = 20;
  localparam int RW_LO    = 40;
  localparam int FLD_W    = 4;

  function automatic logic [AW-1:0] cnt_offset(input int idx);
    case (idx)
      0:       return 12'h380;
      1:       return 12'h3C0;
      2:       return 12'h700;
      default: return 12'h740;
    endcase
  endfunction
endpackage

// File: rtl/itc_rst_sync.sv
module itc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage1     <= 1'b1;
      rst_sync_n <= stage1;
    end
  end
endmodule

// File: rtl/itc_rise.sv
module itc_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic level_d,
  output logic rise
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_d <= 1'b0;
    else        level_d <= level;
  end

  assign rise = level & ~level_d;
endmodule

// File: rtl/itc_skip_cnt.sv
module itc_skip_cnt #(
  parameter int W = 25
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-2:0] load_val,
  input  logic         step,
  output logic [W-1:0] value,
  output logic         ovf_hit
);
  logic [W-1:0] dec_val;
  logic [W-1:0] value_nxt;
  logic         value_en;

  always_comb begin
    dec_val        = value - 1'b1;
    dec_val[W-1]   = dec_val[W-1] | value[W-1];
    value_en       = load | step;
    if (load)      value_nxt = {1'b0, load_val};
    else if (step) value_nxt = dec_val;
    else           value_nxt = value;
    ovf_hit        = step & ~load & dec_val[W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        value <= '0;
    else if (value_en) value <= value_nxt;
  end
endmodule

// File: rtl/itc_ctrl_word.sv
module itc_ctrl_word
  import itc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [DW-1:0]   wdata,
  input  logic [NCPU-1:0] tmr_set,
  output logic [DW-1:0]   q
);
  logic [DW-1:0] q_nxt;
  logic          q_en;
  logic          unused_wd;

  assign unused_wd = ^{wdata[DW-1:RW_LO+FLD_W], wdata[RW_LO-1:29],
                       wdata[27:SET_LO+FLD_W], wdata[TMR_LO-1:0]};

  always_comb begin
    q_nxt = q;
    if (wr) begin
      q_nxt = q_nxt & ~(wdata & CLR1_MASK);
      if (wdata[WIPE_BIT]) begin
        q_nxt[ONCE_LO +: 2*FLD_W] = '0;
      end else begin
        q_nxt[SET_LO +: FLD_W] = q[SET_LO +: FLD_W] | wdata[SET_LO +: FLD_W];
        if (q[ONCE_LO +: FLD_W] == '0)
          q_nxt[ONCE_LO +: FLD_W] = wdata[ONCE_LO +: FLD_W];
      end
      q_nxt[IPI_LO +: NCPU] = q_nxt[IPI_LO +: NCPU] | wdata[REQ_LO +: NCPU];
      q_nxt[RW_LO +: FLD_W] = wdata[RW_LO +: FLD_W];
    end
    q_nxt[TMR_LO +: NCPU] = q_nxt[TMR_LO +: NCPU] | tmr_set;
    q_en = wr | (|tmr_set);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= CTRL_RST;
    else if (q_en) q <= q_nxt;
  end
endmodule

// File: rtl/ipi_timer_ctl.sv
module ipi_timer_ctl
  import itc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  logic [IDW-1:0]  cpu_id,
  input  logic            tick,
  output logic [DW-1:0]   rdata,
  output logic            rd_err,
  output logic [NCPU-1:0] ipi_o,
  output logic [NCPU-1:0] tmr_irq_o
);
  logic                rst_sync_n;
  logic                tick_d;
  logic                tick_rise;
  logic                ctrl_sel;
  logic [NCPU-1:0]     cnt_sel;
  logic [NCPU-1:0]     cnt_ovf;
  logic [CNT_W-1:0]    cnt_val [NCPU];
  logic [DW-1:0]       ctrl_q;

  itc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  itc_rise u_tick (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .level   (tick),
    .level_d (tick_d),
    .rise    (tick_rise)
  );

  assign ctrl_sel = (addr == OFF_CTRL);

  for (genvar g = 0; g < NCPU; g++) begin : g_cpu
    assign cnt_sel[g] = (addr == cnt_offset(g));

    itc_skip_cnt #(.W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .load     (wr_en & cnt_sel[g]),
      .load_val (wdata[LOAD_W-1:0]),
      .step     (tick_rise),
      .value    (cnt_val[g]),
      .ovf_hit  (cnt_ovf[g])
    );
  end

  itc_ctrl_word u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr      (wr_en & ctrl_sel),
    .wdata   (wdata),
    .tmr_set (cnt_ovf),
    .q       (ctrl_q)
  );

  assign ipi_o     = ctrl_q[IPI_LO +: NCPU];
  assign tmr_irq_o = ctrl_q[TMR_LO +: NCPU];

  always_comb begin
    rdata  = '1;
    rd_err = rd_en;
    if (ctrl_sel) begin
      rdata  = ctrl_q | {{(DW-IDW){1'b0}}, cpu_id};
      rd_err = 1'b0;
    end
    for (int i = 0; i < NCPU; i++) begin
      if (cnt_sel[i]) begin
        rdata  = {{(DW-CNT_W){1'b0}}, cnt_val[i]};
        rd_err = 1'b0;
      end
    end
  end
endmodule

// File: rtl/itc_checker.sv
module itc_checker
  import itc_pkg::*;
(
  input logic            clk,
  input logic            rst_sync_n,
  input logic            wr_en,
  input logic            rd_en,
  input logic [AW-1:0]   addr,
  input logic [DW-1:0]   wdata,
  input logic [DW-1:0]   rdata,
  input logic            rd_err,
  input logic            tick,
  input logic            tick_d,
  input logic [NCPU-1:0] ipi_o,
  input logic [NCPU-1:0] tmr_irq_o
);
  logic unused_ck;
  assign unused_ck = ^{wdata, ipi_o};

  assert_ipi_req_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && addr == OFF_CTRL && wdata[REQ_LO]) |=> ipi_o[0]);

  assert_unmapped_read_R12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_err |-> (rd_en && rdata == '1));

  assert_tmr_clear_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && addr == OFF_CTRL && wdata[TMR_LO] && !(tick && !tick_d)) |=> !tmr_irq_o[0]);

  assert_tmr_only_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|(tmr_irq_o & ~$past(tmr_irq_o))) |-> $past(tick && !tick_d));

  assert_wipe_byte_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && addr == OFF_CTRL && wdata[WIPE_BIT]) ##1 (rd_en && addr == OFF_CTRL)
      |-> rdata[ONCE_LO +: 2*FLD_W] == '0);
endmodule

bind ipi_timer_ctl itc_checker u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .addr       (addr),
  .wdata      (wdata),
  .rdata      (rdata),
  .rd_err     (rd_err),
  .tick       (tick),
  .tick_d     (tick_d),
  .ipi_o      (ipi_o),
  .tmr_irq_o  (tmr_irq_o)
);

// File: tb/ipi_timer_ctl_bench.sv
module ipi_timer_ctl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [63:0] wdata = '0;
  logic [1:0]  cpu_id = '0;
  logic        tick = 1'b0;
  logic [63:0] rdata;
  logic        rd_err;
  logic [3:0]  ipi_o;
  logic [3:0]  tmr_irq_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ipi_timer_ctl u_ipi_timer_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .cpu_id(cpu_id), .tick(tick), .rdata(rdata),
    .rd_err(rd_err), .ipi_o(ipi_o), .tmr_irq_o(tmr_irq_o)
  );

  // behavioural reference model
  logic [63:0] m_ctrl;
  logic [24:0] m_cnt [4];
  logic        m_tick_q;

  function automatic int cnt_idx(input logic [11:0] a);
    case (a)
      12'h380: return 0;
      12'h3C0: return 1;
      12'h700: return 2;
      12'h740: return 3;
      default: return -1;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl   = 64'h0000_0008_0000_0000;
      for (int i = 0; i < 4; i++) m_cnt[i] = '0;
      m_tick_q = 1'b0;
    end else begin
      bit rise;
      bit loaded [4];
      rise     = tick && !m_tick_q;
      m_tick_q = tick;
      for (int i = 0; i < 4; i++) loaded[i] = 1'b0;
      if (wr_en) begin
        if (addr == 12'h080) begin
          logic [63:0] old;
          old    = m_ctrl;
          m_ctrl = m_ctrl & ~(wdata & 64'h1000_0FF0);
          if (wdata[20]) m_ctrl[23:16] = 8'h00;
          else begin
            m_ctrl[23:20] = m_ctrl[23:20] | wdata[23:20];
            if (old[19:16] == 4'h0) m_ctrl[19:16] = wdata[19:16];
          end
          m_ctrl[11:8]  = m_ctrl[11:8] | wdata[15:12];
          m_ctrl[43:40] = wdata[43:40];
        end else if (cnt_idx(addr) >= 0) begin
          m_cnt[cnt_idx(addr)]  = {1'b0, wdata[23:0]};
          loaded[cnt_idx(addr)] = 1'b1;
        end
      end
      if (rise) begin
        for (int i = 0; i < 4; i++) begin
          if (!loaded[i]) begin
            m_cnt[i] = (m_cnt[i] - 25'd1) | (m_cnt[i] & 25'h100_0000);
            if (m_cnt[i][24]) m_ctrl[4+i] = 1'b1;
          end
        end
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // outputs compared with the model on every clock (R6, R10)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R6 ipi_o", {60'd0, ipi_o}, {60'd0, m_ctrl[11:8]});
      chk("R10 tmr_irq_o", {60'd0, tmr_irq_o}, {60'd0, m_ctrl[7:4]});
    end
  end

  task automatic wr(input logic [11:0] a, input logic [63:0] d, input bit with_tick = 1'b0);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    if (with_tick) tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (with_tick) tick = 1'b0;
  endtask

  task automatic rd(input string req, input logic [11:0] a, input logic [63:0] exp, input bit exp_err = 1'b0);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1;
    chk(req, rdata, exp);
    chk({req, " err"}, {63'd0, rd_err}, {63'd0, exp_err});
    rd_en = 1'b0;
  endtask

  task automatic pulse(input int hi, input int lo);
    @(negedge clk);
    tick = 1'b1;
    repeat (hi) @(negedge clk);
    tick = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog expired");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state, R2 id merge
    cpu_id = 2'd2;
    rd("R1 R2 ctrl reset", 12'h080, 64'h0000_0008_0000_0002);
    rd("R1 cnt0 reset", 12'h380, 64'd0);
    rd("R1 cnt3 reset", 12'h740, 64'd0);
    chk("R1 outputs", {56'd0, ipi_o, tmr_irq_o}, 64'd0);
    cpu_id = 2'd3;
    rd("R2 id 3", 12'h080, 64'h0000_0008_0000_0003);
    cpu_id = 2'd0;

    // R6 requests, R3 clears, set wins
    wr(12'h080, 64'h0000_F000);
    rd("R6 all ipi", 12'h080, 64'h0000_0008_0000_0F00);
    wr(12'h080, 64'h0000_0100);
    rd("R3 clear ipi0", 12'h080, 64'h0000_0008_0000_0E00);
    wr(12'h080, 64'h0000_1300);
    rd("R6 set beats clear", 12'h080, 64'h0000_0008_0000_0D00);

    // R4 / R5 field rules
    wr(12'h080, 64'h00C0_0000);
    rd("R4 upper set", 12'h080, m_ctrl);
    wr(12'h080, 64'h000A_0000);
    rd("R5 once field", 12'h080, 64'h0000_0008_00CA_0D00);
    wr(12'h080, 64'h0005_0000);
    rd("R5 nonzero kept", 12'h080, 64'h0000_0008_00CA_0D00);
    wr(12'h080, 64'h0013_0000);
    rd("R4 wipe", 12'h080, 64'h0000_0008_0000_0D00);
    wr(12'h080, 64'h0003_0000);
    rd("R5 refill", 12'h080, 64'h0000_0008_0003_0D00);

    // R7 read/write nibble, untouched bits
    wr(12'h080, 64'h0000_0A00_0000_0000);
    rd("R7 rw nibble", 12'h080, 64'h0000_0A08_0003_0D00);
    wr(12'h080, 64'hFFFF_FFFF_FFFF_FFFF);
    rd("R7 all ones", 12'h080, 64'h0000_0F08_0000_0F00);
    wr(12'h080, 64'h0000_0000_0000_0F00);
    rd("R3 clear all ipi", 12'h080, 64'h0000_0008_0000_0000);

    // R12 unmapped
    wr(12'h088, 64'hFFFF_FFFF_FFFF_F000);
    rd("R12 write ignored", 12'h080, 64'h0000_0008_0000_0000);
    rd("R12 unmapped read", 12'h090, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);

    // R8 counter load
    wr(12'h380, 64'hFFFF_FFFF_FFFF_FFFF);
    rd("R8 load truncates", 12'h380, 64'h00FF_FFFF);
    wr(12'h380, 64'd0);
    wr(12'h3C0, 64'd2);
    wr(12'h700, 64'd9);
    wr(12'h740, 64'd1);

    // R9 single decrement for long pulse, wrap sets overflow R10
    pulse(3, 2);
    rd("R9 cnt0 wrap", 12'h380, 64'h01FF_FFFF);
    rd("R9 cnt1 once", 12'h3C0, 64'd1);
    rd("R9 cnt2", 12'h700, 64'd8);
    chk("R10 tmr0 up", {63'd0, tmr_irq_o[0]}, 64'd1);
    pulse(1, 1);
    pulse(1, 1);
    rd("R9 cnt1 wrap", 12'h3C0, 64'h01FF_FFFF);
    rd("R9 cnt3 wrap", 12'h740, 64'h01FF_FFFE);
    rd("R10 tmr bits", 12'h080, m_ctrl);

    // R10 clear, then sticky reassert
    wr(12'h080, 64'h0000_00F0);
    chk("R10 tmr cleared", {60'd0, tmr_irq_o}, 64'd0);
    pulse(1, 1);
    chk("R9 sticky", {60'd0, tmr_irq_o}, 64'hB);

    // R11 tick set beats clear in same cycle
    wr(12'h080, 64'h0000_0010, 1'b1);
    chk("R11 set wins", {63'd0, tmr_irq_o[0]}, 64'd1);
    @(negedge clk);

    // R11 load beats decrement
    wr(12'h080, 64'h0000_00F0);
    wr(12'h380, 64'd5, 1'b1);
    rd("R11 load wins", 12'h380, 64'd5);
    chk("R11 no tmr0", {63'd0, tmr_irq_o[0]}, 64'd0);
    rd("R8 load clears ovf", 12'h3C0, m_cnt[1]);
    wr(12'h3C0, 64'd7);
    rd("R8 overflow cleared", 12'h3C0, 64'd7);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule